// File: doc/BRIEF.md
# STS-12 Transmit Overhead Insertion Multiplexer

This block sits in the transmit path of one STS-12 channel, between the byte-wide framed data stream and the scrambler and serializer. One byte enters each cycle of the 77.76 MHz byte clock. An external 8 kHz frame pulse marks the first A1 byte of every frame. The block returns the same stream one cycle later. Payload passes through untouched. The framing bytes are regenerated, B1 is recomputed, and selected transport overhead bytes are replaced.

Replacement bytes come from a serial overhead port that has its own clock and a bit enable. Bits are retimed, then shifted into a 36-byte row register. At the end of each row that register is copied into a holding register, and the following row reads its replacement bytes from that copy. A mode input chooses transparent operation or insert operation. In insert mode a 15-bit select word decides, one byte group at a time, whether bytes come from the serial row or from the parallel input. A cleared bit lets the parallel byte through.

Top module: `toh_ins_mux`

## Requirements
- R1: While `rst_ni` is low, `data_o` is 0x00.
- R2: Every byte appears on `data_o` exactly one byte-clock cycle after it is presented on `data_i`. In both modes, a byte in row slots 36 and above is output unchanged.
- R3: The frame is 9 rows of `ROW_SLOTS` slots, and `fp_i` high marks row 0, slot 0. In row 0, slots 0–11 (A1) are output as 0xF6 and slots 12–23 (A2) as 0x28, in both modes.
- R4: Row 1, slot 0 (B1) carries the XOR of every byte output during the previous frame. In the first frame after reset, B1 is 0x00.
- R5: Row 1, slots 1–11 (the bytes after B1) are output as 0x00 in both modes.
- R6: In transparent mode (`insert_mode_i` = 0), every overhead byte other than A1, A2, B1 and its trailing bytes passes from `data_i`. `sel_i` and the serial port have no effect.
- R7: In insert mode, an overhead slot whose group bit is 1 outputs byte k of the held serial row, where k is the slot index 0–35. Byte k is the (k+1)-th byte shifted in, most significant bit first.
- R8: Group bits of `sel_i`: [0] covers K1/K2 (row 4, slots 12–35); [1] covers S1/M0 (row 8, slots 0–23); [2] covers E1/F1/E2 (row 1, slots 12–35, and row 8, slots 24–35); [3+n] covers D(n+1), n = 0..11. D1–D3 are row 2, D4–D6 row 5, D7–D9 row 6 and D10–D12 row 7, with one group of 12 slots per byte. A group bit of 0 passes `data_i`.
- R9: J0 (row 0, slots 24–35), H1–H3 (row 3, slots 0–35) and B2 (row 4, slots 0–11) always pass from `data_i`.
- R10: `toh_data_i` and `toh_en_i` are registered on `toh_clk_i`, and a bit is shifted only when its retimed enable is 1. The row register is copied to the holding register in the last slot of each row, and the copy is used during the following row.
- R11: Without a frame pulse, the slot counter advances by one slot per cycle through all 9 rows and wraps. A frame pulse at any slot restarts the frame at row 0, slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fp_i | input | 1 | Frame pulse, high on the first A1 byte |
| data_i | input | 8 | Parallel transmit byte |
| insert_mode_i | input | 1 | 1 = insert mode, 0 = transparent mode |
| sel_i | input | 15 | Per-group overhead source select |
| toh_clk_i | input | 1 | Serial overhead clock |
| toh_data_i | input | 1 | Serial overhead data bit |
| toh_en_i | input | 1 | Serial overhead bit enable |
| data_o | output | 8 | Transmit byte to the scrambler |

## Verification
The frame-start slot has two jobs in one cycle. It closes the parity of the previous frame into B1, and its own output byte, an A1, opens the parity of the new frame. An error in either job shows up in the next frame's B1. The bench runs eight full frames and checks every output byte against its own parity model. It also fires one frame pulse early, in the middle of a row, so that a restart coincides with a partial frame's parity close. The B1 that follows must equal the XOR over only that partial frame.

// File: rtl/toh_ins_pkg.sv
package toh_ins_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned STS_N      = 12;
  localparam int unsigned OH_COLS    = 3;
  localparam int unsigned OH_BYTES   = STS_N * OH_COLS;
  localparam int unsigned OH_IDX_W   = $clog2(OH_BYTES);
  localparam int unsigned FRAME_ROWS = 9;
  localparam int unsigned ROW_W      = $clog2(FRAME_ROWS);
  localparam int unsigned SEL_W      = 15;
  localparam int unsigned SR_W       = OH_BYTES * BYTE_W;

  typedef enum logic [2:0] {
    SLOT_PASS, SLOT_A1, SLOT_A2, SLOT_B1, SLOT_B1Z, SLOT_INS
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e kind;
    logic [3:0] sel_idx;
  } slot_t;

  // grp: overhead column 0..2, lead: first interleaved byte of the row
  function automatic slot_t slot_decode(input logic [ROW_W-1:0] row,
                                        input logic [1:0] grp,
                                        input logic lead);
    slot_t s;
    s.kind    = SLOT_PASS;
    s.sel_idx = '0;
    case (row)
      4'd0: begin
        if (grp == 2'd0) s.kind = SLOT_A1;
        else if (grp == 2'd1) s.kind = SLOT_A2;
      end
      4'd1: begin
        if (grp == 2'd0) s.kind = lead ? SLOT_B1 : SLOT_B1Z;
        else begin s.kind = SLOT_INS; s.sel_idx = 4'd2; end
      end
      4'd2: begin s.kind = SLOT_INS; s.sel_idx = 4'(3 + int'(grp)); end
      4'd4: begin
        if (grp != 2'd0) begin s.kind = SLOT_INS; s.sel_idx = 4'd0; end
      end
      4'd5, 4'd6, 4'd7: begin
        s.kind    = SLOT_INS;
        s.sel_idx = 4'(3 * int'(row) + int'(grp) - 9);
      end
      4'd8: begin
        s.kind    = SLOT_INS;
        s.sel_idx = (grp == 2'd2) ? 4'd2 : 4'd1;
      end
      default: ;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/toh_slot_cnt.sv
module toh_slot_cnt
  import toh_ins_pkg::*;
#(
  parameter int unsigned ROW_SLOTS = 1080,
  localparam int unsigned COL_W    = $clog2(ROW_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             frame_start_o,
  output logic             row_last_o
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(ROW_SLOTS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(FRAME_ROWS - 1);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  // frame pulse overrides the running position in its own cycle
  always_comb begin
    row_o         = fp_i ? '0 : row_q;
    col_o         = fp_i ? '0 : col_q;
    frame_start_o = (row_o == '0) && (col_o == '0);
    row_last_o    = (col_o == COL_LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else if (row_last_o) begin
      col_q <= '0;
      row_q <= (row_o == ROW_LAST) ? '0 : row_o + 1'b1;
    end else begin
      col_q <= col_o + 1'b1;
      row_q <= row_o;
    end
  end
endmodule

// File: rtl/toh_serial_row.sv
module toh_serial_row
  import toh_ins_pkg::*;
#(
  parameter int unsigned SR_BITS = SR_W
) (
  input  logic               toh_clk_i,
  input  logic               rst_ni,
  input  logic               toh_d_i,
  input  logic               toh_en_i,
  input  logic               clk_i,
  input  logic               copy_i,
  output logic [SR_BITS-1:0] hold_o
);
  logic               d_q, en_q;
  logic [SR_BITS-1:0] sr_q;

  always_ff @(posedge toh_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q  <= 1'b0;
      en_q <= 1'b0;
      sr_q <= '0;
    end else begin
      d_q  <= toh_d_i;
      en_q <= toh_en_i;
      if (en_q) sr_q <= {sr_q[SR_BITS-2:0], d_q};
    end
  end

  // loader must be idle at the copy slot; the copy is quasi-static by protocol
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_o <= '0;
    else if (copy_i) hold_o <= sr_q;
  end
endmodule

// File: rtl/toh_bip8.sv
module toh_bip8 #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] bip_o
);
  logic [W-1:0] acc_q;
  logic         seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      seen_q <= 1'b0;
      bip_o  <= '0;
    end else if (start_i) begin
      bip_o  <= seen_q ? acc_q : '0;
      seen_q <= 1'b1;
      acc_q  <= byte_i;
    end else begin
      acc_q  <= acc_q ^ byte_i;
    end
  end
endmodule

// File: rtl/toh_ins_mux.sv
module toh_ins_mux
  import toh_ins_pkg::*;
#(
  parameter int unsigned ROW_SLOTS = 1080,
  parameter logic [7:0]  A1_VAL    = 8'hF6,
  parameter logic [7:0]  A2_VAL    = 8'h28,
  localparam int unsigned COL_W    = $clog2(ROW_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              insert_mode_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              toh_clk_i,
  input  logic              toh_data_i,
  input  logic              toh_en_i,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned HB_N = 2 ** OH_IDX_W;

  logic [ROW_W-1:0]    row_w;
  logic [COL_W-1:0]    col_w;
  logic                frame_start, row_last;
  logic [SR_W-1:0]     hold;
  logic [BYTE_W-1:0]   bip, out_d;
  logic [BYTE_W-1:0]   hold_bytes [HB_N];
  logic [OH_IDX_W-1:0] oh_idx;
  logic [1:0]          grp;
  logic                in_oh;
  logic [SEL_W:0]      sel_ext;
  slot_t               slot;

  toh_slot_cnt #(.ROW_SLOTS(ROW_SLOTS)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp_i),
    .row_o(row_w), .col_o(col_w),
    .frame_start_o(frame_start), .row_last_o(row_last)
  );

  toh_serial_row #(.SR_BITS(SR_W)) u_row (
    .toh_clk_i(toh_clk_i), .rst_ni(rst_ni),
    .toh_d_i(toh_data_i), .toh_en_i(toh_en_i),
    .clk_i(clk_i), .copy_i(row_last), .hold_o(hold)
  );

  toh_bip8 #(.W(BYTE_W)) u_bip (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(frame_start),
    .byte_i(out_d), .bip_o(bip)
  );

  // first shifted byte sits at the top of the row register
  for (genvar k = 0; k < HB_N; k++) begin : g_hb
    if (k < OH_BYTES) begin : g_used
      assign hold_bytes[k] = hold[SR_W-1-BYTE_W*k -: BYTE_W];
    end else begin : g_unused
      assign hold_bytes[k] = '0;
    end
  end

  always_comb begin
    in_oh   = int'(col_w) < OH_BYTES;
    oh_idx  = OH_IDX_W'(col_w);
    grp     = 2'(int'(oh_idx) / STS_N);
    sel_ext = {1'b0, sel_i};
    slot    = in_oh ? slot_decode(row_w, grp, oh_idx == '0)
                    : slot_t'{kind: SLOT_PASS, sel_idx: 4'd0};
    case (slot.kind)
      SLOT_A1:  out_d = A1_VAL;
      SLOT_A2:  out_d = A2_VAL;
      SLOT_B1:  out_d = bip;
      SLOT_B1Z: out_d = '0;
      SLOT_INS: out_d = (insert_mode_i && sel_ext[slot.sel_idx])
                        ? hold_bytes[oh_idx] : data_i;
      default:  out_d = data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= out_d;
  end
endmodule

// File: rtl/toh_ins_mux_chk.sv
module toh_ins_mux_chk
  import toh_ins_pkg::*;
#(
  parameter int unsigned ROW_SLOTS = 1080,
  parameter logic [7:0]  A1_VAL    = 8'hF6,
  parameter logic [7:0]  A2_VAL    = 8'h28,
  localparam int unsigned COL_W    = $clog2(ROW_SLOTS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fp_i,
  input logic              insert_mode_i,
  input logic [BYTE_W-1:0] data_i,
  input logic [BYTE_W-1:0] data_o,
  input logic [ROW_W-1:0]  row_i,
  input logic [COL_W-1:0]  col_i
);
  logic              oh, fp_q, pay_q, tail_q, fixp_q, trov_q;
  logic [BYTE_W-1:0] din_q;
  int unsigned       g;

  always_comb begin
    oh = int'(col_i) < OH_BYTES;
    g  = int'(col_i) / STS_N;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp_q <= 1'b0; pay_q <= 1'b0; tail_q <= 1'b0;
      fixp_q <= 1'b0; trov_q <= 1'b0; din_q <= '0;
    end else begin
      fp_q   <= fp_i;
      din_q  <= data_i;
      pay_q  <= !oh;
      tail_q <= (row_i == 4'd1) && (col_i != '0) && oh && (g == 0);
      fixp_q <= oh && ((row_i == 4'd3) || (row_i == 4'd0 && g == 2) ||
                       (row_i == 4'd4 && g == 0));
      trov_q <= oh && !insert_mode_i && !(row_i == 4'd0 && g < 2) &&
                !(row_i == 4'd1 && g == 0);
    end
  end

  assert_a1_on_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_q |-> data_o == A1_VAL);
  assert_payload_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_q |-> data_o == din_q);
  assert_b1_tail_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_q |-> data_o == '0);
  assert_fixed_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fixp_q |-> data_o == din_q);
  assert_transparent_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trov_q |-> data_o == din_q);
  assert_slot_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(row_i) < FRAME_ROWS) && (int'(col_i) < ROW_SLOTS));
endmodule

bind toh_ins_mux toh_ins_mux_chk #(
  .ROW_SLOTS(ROW_SLOTS), .A1_VAL(A1_VAL), .A2_VAL(A2_VAL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp_i), .insert_mode_i(insert_mode_i),
  .data_i(data_i), .data_o(data_o), .row_i(row_w), .col_i(col_w)
);

// File: tb/toh_ins_mux_bench.sv
`timescale 1ns/1ps
module toh_ins_mux_bench;
  localparam int SLOTS = 1080;
  localparam int FRAME = 9 * SLOTS;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fp_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic        insert_mode_i = 1'b0;
  logic [14:0] sel_i = '0;
  logic        toh_data_i = 1'b0;
  logic        toh_en_i = 1'b0;
  logic [7:0]  data_o;

  always #2.5 clk = ~clk;

  toh_ins_mux u_toh_ins_mux (
    .clk_i(clk), .rst_ni(rst_ni), .fp_i(fp_i), .data_i(data_i),
    .insert_mode_i(insert_mode_i), .sel_i(sel_i), .toh_clk_i(clk),
    .toh_data_i(toh_data_i), .toh_en_i(toh_en_i), .data_o(data_o)
  );

  int   checks = 0, fails = 0;
  bit   done = 0;
  int   m_row = 0, m_col = 0, n_row = 0, n_col = 0;
  bit   started = 0;
  logic [7:0] acc = '0, b1m = '0;
  logic [7:0] ldbuf [36];
  logic [7:0] hold_m [36];
  bit   mode = 0;
  logic [14:0] sel = '0;

  task automatic check(input logic [7:0] exp, input string tag, input int r, input int c);
    checks++;
    if (data_o !== exp) begin
      fails++;
      $display("FAIL %s row %0d slot %0d: got %02h expected %02h", tag, r, c, data_o, exp);
    end
  endtask

  // reference from the requirement text; R8 gives the group numbering
  function automatic logic [7:0] model(input int r, input int c, input logic [7:0] din,
                                       output string tag);
    int g, sidx;
    g = c / 12;
    sidx = -1;
    if (c >= 36) begin tag = "R2"; return din; end
    if (r == 0 && g == 0) begin tag = "R3"; return 8'hF6; end
    if (r == 0 && g == 1) begin tag = "R3"; return 8'h28; end
    if (r == 1 && c == 0) begin tag = "R4"; return b1m; end
    if (r == 1 && g == 0) begin tag = "R5"; return 8'h00; end
    case (r)
      1: sidx = 2;
      2: sidx = 3 + g;
      4: sidx = (g > 0) ? 0 : -1;
      5, 6, 7: sidx = 3 * r - 9 + g;
      8: sidx = (g == 2) ? 2 : 1;
      default: sidx = -1;
    endcase
    if (sidx < 0) begin tag = "R9"; return din; end
    if (!mode) begin tag = "R6"; return din; end
    if (sel[sidx]) begin tag = "R7 R10"; return hold_m[c]; end
    tag = "R8";
    return din;
  endfunction

  // one byte slot: drive, let the edge pass, check the registered output
  task automatic step(input bit fp);
    logic [7:0] din, exp;
    string tag;
    if (fp) begin m_row = 0; m_col = 0; end
    else begin m_row = n_row; m_col = n_col; end
    if (m_col == 0)
      for (int k = 0; k < 36; k++) ldbuf[k] = 8'($urandom);
    if (m_row == 0 && m_col == 0) begin
      b1m = started ? acc : 8'h00;
    end
    din = 8'($urandom);
    exp = model(m_row, m_col, din, tag);
    if (m_row == 0 && m_col == 0) begin acc = exp; started = 1; end
    else acc = acc ^ exp;
    fp_i = fp; data_i = din; insert_mode_i = mode; sel_i = sel;
    if (m_col < 288) begin
      toh_data_i = ldbuf[m_col / 8][7 - (m_col % 8)];
      toh_en_i = 1'b1;
    end else begin
      toh_data_i = 1'($urandom); // R10: disabled bits must not shift
      toh_en_i = 1'b0;
    end
    if (m_col == SLOTS - 1)
      for (int k = 0; k < 36; k++) hold_m[k] = ldbuf[k];
    if (m_col == SLOTS - 1) begin
      n_col = 0;
      n_row = (m_row == 8) ? 0 : m_row + 1; // R11 wrap
    end else begin
      n_col = m_col + 1; n_row = m_row;
    end
    @(negedge clk);
    check(exp, tag, m_row, m_col);
  endtask

  task automatic run(input bit md, input logic [14:0] s, input int n, input bit fp_first);
    mode = md; sel = s;
    for (int i = 0; i < n; i++) step(fp_first && i == 0);
  endtask

  initial begin
    for (int k = 0; k < 36; k++) begin ldbuf[k] = '0; hold_m[k] = '0; end
    repeat (3) @(negedge clk);
    checks++; if (data_o !== 8'h00) begin fails++; $display("FAIL R1 reset: got %02h expected 00", data_o); end
    @(negedge clk);
    checks++; if (data_o !== 8'h00) begin fails++; $display("FAIL R1 reset: got %02h expected 00", data_o); end
    rst_ni = 1'b1;
    run(0, 15'h7FFF, FRAME, 1);       // transparent, serial active
    run(1, 15'h7FFF, FRAME, 1);       // all groups inserted
    run(1, 15'h0000, FRAME, 1);       // all groups pass
    run(1, 15'h5555, FRAME, 1);
    run(1, 15'h2AAA, FRAME, 1);
    run(1, 15'($urandom), FRAME, 1);
    run(0, 15'($urandom), FRAME, 1);
    run(1, 15'($urandom), 2 * SLOTS + 500, 1);
    run(1, 15'($urandom), FRAME, 1);  // R11 early pulse mid-row
    run(1, 15'($urandom), SLOTS + 40, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(190000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog: got hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule